// File: doc/BRIEF.md
# Serial Master Frame Select Sequencer

This block is the master side of a four-wire serial link: it drives an active-low select line, a shift clock that idles low, and a serial data output, and it samples a serial data input. Words are shifted MSB first. Data changes on the falling clock edge and is sampled on the rising edge. One frame may carry several words, and the select line stays low for the whole frame.

Software opens a frame with a set strobe on a frame-active bit. It closes the frame in one of two ways: a one written to a separate clear strobe, or an end-of-frame tag on the last transmit word. Three programmable spacings shape the select line. The leading spacing runs from select assertion to the first bit. The trailing spacing runs from the last bit to select release. The next-frame spacing runs from select release until another frame may start. Each spacing is a field value plus one, counted in whole shift-clock periods (1 to 16 with 4-bit fields). Clearing the frame-active bit never cuts a word short: a word already on the wire always finishes first.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, select is high (1), the shift clock is 0, tx_ready is 0, frame_active_o is 0, rx_valid_o is 0 and xfer_done_o is 0.
- R2: The shift clock stays low while select is high. The first rising shift-clock edge of a frame follows the falling edge of select by exactly 2·HALF_DIV·L + HALF_DIV + 1 clock cycles, where L = cfg_lead + 1, provided a word is waiting.
- R3: Each word is WORD_W bits long and goes out MSB first. mosi_o changes after falling shift-clock edges, and miso_i is sampled on rising edges. After the WORD_W-th rising edge, rx_valid_o pulses for one cycle with the received bits in rx_data_o, the first bit in the MSB.
- R4: While the frame-active bit is set and a further word is offered, consecutive words are shifted without select going high between them.
- R5: A clear strobe that arrives while a word is shifting lets that word finish with all WORD_W clock edges. The trailing spacing then follows.
- R6: Select rises exactly 2·HALF_DIV·T clock cycles after the last falling shift-clock edge of a frame, where T = cfg_trail + 1.
- R7: After select rises, it stays high for 2·HALF_DIV·G + 1 clock cycles before the next frame, when a frame and a word are already pending. G = cfg_gap + 1.
- R8: A clear strobe during the leading spacing sends no data. No shift-clock edge occurs and no word is accepted. Select stays low for 2·HALF_DIV·(L + T) cycles, and the next-frame spacing then follows.
- R9: A word accepted with tx_eof_i = 1 closes the frame: frame_active_o drops when that word completes, and the trailing spacing follows.
- R10: xfer_done_o is set when a word completes and stays set until a done_clr_i strobe clears it.
- R11: When set and clear strobes arrive in the same cycle, the clear wins. tx_ready_o is high only while the frame-active bit is set and the sequencer is waiting for a word inside an open frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lead | input | DLY_W | Leading spacing, periods minus one |
| cfg_trail | input | DLY_W | Trailing spacing, periods minus one |
| cfg_gap | input | DLY_W | Next-frame spacing, periods minus one |
| frame_set_i | input | 1 | Strobe that sets the frame-active bit |
| frame_clr_i | input | 1 | Write-one strobe that clears the frame-active bit |
| frame_active_o | output | 1 | Frame-active bit |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_data_i | input | WORD_W | Transmit word |
| tx_eof_i | input | 1 | Word closes the frame |
| tx_ready_o | output | 1 | Transmit word accepted in this cycle when valid |
| sclk_o | output | 1 | Shift clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Active-low select |
| rx_data_o | output | WORD_W | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_data_o is updated |
| done_clr_i | input | 1 | Strobe that clears xfer_done_o |
| xfer_done_o | output | 1 | Sticky word-complete flag |

## Verification
The bench builds the block with WORD_W = 8 and HALF_DIV = 2, so one shift-clock period lasts four clock cycles and every spacing can be predicted to the exact cycle. The 4-bit delay fields cover the shortest spacing (one period) and the longest (sixteen periods, 67 cycles before the first edge). The 8-bit word keeps a three-word frame short enough to let a mid-word clear and a back-to-back frame restart run in one pass. An inverting loopback on the serial lines lets the scoreboard predict each received word from the word it sent.

// File: rtl/spi_fsel_pkg.sv
package spi_fsel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HOLD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } seq_state_e;

  // Terminal half-period count for a spacing field: (field+1) periods,
  // two half-period ticks each, counted down to zero.
  function automatic logic [8:0] span_last(input logic [7:0] field);
    return 9'(field) * 9'd2 + 9'd1;
  endfunction

endpackage

// File: rtl/spi_fsel_tick.sv
module spi_fsel_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_q;

  assign tick = run && (div_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  a_r2_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/spi_fsel_shifter.sv
module spi_fsel_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              active,
  input  logic              tick,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] tx_sh, rx_sh, rx_q;
  logic [BW-1:0]     bit_q;
  logic              high_q;   // 1: next tick is a falling edge
  logic              sclk_q, rxv_q;

  assign word_done = active && tick && high_q && (bit_q == BW'(WORD_W - 1));
  assign mosi      = tx_sh[WORD_W-1];
  assign sclk      = sclk_q;
  assign rx_word   = rx_q;
  assign rx_valid  = rxv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      high_q <= 1'b0;
      sclk_q <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= word_done;
      if (word_done) rx_q <= rx_sh;
      if (load) begin
        tx_sh  <= load_data;
        bit_q  <= '0;
        high_q <= 1'b0;
        sclk_q <= 1'b0;
      end else if (active && tick) begin
        if (!high_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[WORD_W-2:0], miso};
          high_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          tx_sh  <= tx_sh << 1;
          high_q <= 1'b0;
          bit_q  <= word_done ? '0 : bit_q + 1'b1;
        end
      end
    end
  end

  // R3: a word is only loaded while the shift clock is low
  a_r3_load_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sclk_q);

endmodule

// File: rtl/spi_fsel_seq.sv
module spi_fsel_seq
  import spi_fsel_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] cfg_lead,
  input  logic [DLY_W-1:0] cfg_trail,
  input  logic [DLY_W-1:0] cfg_gap,
  input  logic             frame_set,
  input  logic             frame_clr,
  input  logic             done_clr,
  input  logic             tx_valid,
  input  logic             tx_eof,
  input  logic             tick,
  input  logic             word_done,
  output logic             tx_ready,
  output logic             load,
  output logic             run,
  output logic             in_shift,
  output logic             ss_n,
  output logic             frame_active,
  output logic             xfer_done
);
  localparam int CNT_W = DLY_W + 1;

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             frame_q, frame_d, eof_q, done_q, cnt_end;

  assign tx_ready     = (st_q == ST_HOLD) && frame_q;
  assign load         = tx_ready && tx_valid;
  assign run          = (st_q == ST_LEAD) || (st_q == ST_SHIFT) ||
                        (st_q == ST_TRAIL) || (st_q == ST_GAP);
  assign in_shift     = (st_q == ST_SHIFT);
  assign ss_n         = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign frame_active = frame_q;
  assign xfer_done    = done_q;
  assign cnt_end      = tick && (cnt_q == '0);

  always_comb begin
    if (frame_clr || (word_done && eof_q)) frame_d = 1'b0;
    else if (frame_set)                    frame_d = 1'b1;
    else                                   frame_d = frame_q;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = tick ? cnt_q - 1'b1 : cnt_q;
    unique case (st_q)
      ST_IDLE: if (frame_q && tx_valid) begin
        st_d  = ST_LEAD;
        cnt_d = CNT_W'(span_last(8'(cfg_lead)));
      end
      ST_LEAD: if (cnt_end) begin
        st_d  = frame_q ? ST_HOLD : ST_TRAIL;
        cnt_d = CNT_W'(span_last(8'(cfg_trail)));
      end
      ST_HOLD: if (!frame_q) begin
        st_d  = ST_TRAIL;
        cnt_d = CNT_W'(span_last(8'(cfg_trail)));
      end else if (tx_valid) begin
        st_d = ST_SHIFT;
      end
      ST_SHIFT: if (word_done) begin
        st_d  = frame_d ? ST_HOLD : ST_TRAIL;
        cnt_d = CNT_W'(span_last(8'(cfg_trail)));
      end
      ST_TRAIL: if (cnt_end) begin
        st_d  = ST_GAP;
        cnt_d = CNT_W'(span_last(8'(cfg_gap)));
      end
      ST_GAP: if (cnt_end) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      frame_q <= 1'b0;
      eof_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
      if (load) eof_q <= tx_eof;
      if (word_done)     done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  // R5: the shift state is only left when the word has completed
  a_r5_word_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q == ST_SHIFT) && (st_q != ST_SHIFT)) |-> $past(word_done));
  // R4: select held low while a word shifts
  a_r4_select_low_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |-> !ss_n);
  // R10: completion sets the sticky flag
  a_r10_done_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> xfer_done);
  // R11: a clear strobe blocks acceptance in the next cycle
  a_r11_no_accept_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> !tx_ready);

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int DLY_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  cfg_lead,
  input  logic [DLY_W-1:0]  cfg_trail,
  input  logic [DLY_W-1:0]  cfg_gap,
  input  logic              frame_set_i,
  input  logic              frame_clr_i,
  output logic              frame_active_o,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_eof_i,
  output logic              tx_ready_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_n_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              done_clr_i,
  output logic              xfer_done_o
);
  logic tick, run, load, in_shift, word_done;

  spi_fsel_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_fsel_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_gap(cfg_gap),
    .frame_set(frame_set_i), .frame_clr(frame_clr_i), .done_clr(done_clr_i),
    .tx_valid(tx_valid_i), .tx_eof(tx_eof_i),
    .tick(tick), .word_done(word_done),
    .tx_ready(tx_ready_o), .load(load), .run(run), .in_shift(in_shift),
    .ss_n(ss_n_o), .frame_active(frame_active_o), .xfer_done(xfer_done_o)
  );

  spi_fsel_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_data(tx_data_i), .active(in_shift), .tick(tick),
    .miso(miso_i), .mosi(mosi_o), .sclk(sclk_o), .word_done(word_done),
    .rx_word(rx_data_o), .rx_valid(rx_valid_o)
  );

  // R2: no shift clock while the slave is deselected
  a_r2_clock_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> !sclk_o);

endmodule

// File: tb/spi_frame_master_tb_top.sv
module spi_frame_master_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int H     = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cfg_lead = 4'd1, cfg_trail = 4'd2, cfg_gap = 4'd0;
  logic frame_set = 0, frame_clr = 0, done_clr = 0;
  logic tx_valid = 0, tx_eof = 0;
  logic [W-1:0] tx_data = '0, rx_data;
  logic frame_active, tx_ready, sclk, mosi, miso, ss_n, rx_valid, xfer_done;

  always #(CLK_P/2) clk = ~clk;
  assign miso = ~mosi;   // inverting loopback slave

  spi_frame_master #(.WORD_W(W), .HALF_DIV(H), .DLY_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .cfg_gap(cfg_gap), .frame_set_i(frame_set), .frame_clr_i(frame_clr),
    .frame_active_o(frame_active), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_eof_i(tx_eof), .tx_ready_o(tx_ready), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_n_o(ss_n), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .done_clr_i(done_clr), .xfer_done_o(xfer_done)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [W-1:0] exp_rx[$];
  logic [W-1:0] exp_wire[$];

  // monitor
  logic prev_ss = 1'b1, prev_sclk = 1'b0;
  int t_fall = 0, t_rise = 0, first_rise = -1, last_fall = 0, rises = 0;
  int frames = 0, gap_len = -1, accepts = 0, sl_n = 0;
  logic [W-1:0] sl_sh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ss && !ss_n) begin
        if (frames > 0) gap_len = cyc - t_rise;
        t_fall = cyc; rises = 0; first_rise = -1;
      end
      if (!prev_sclk && sclk) begin
        if (first_rise < 0) first_rise = cyc;
        rises++;
        sl_sh = {sl_sh[W-2:0], mosi};
        sl_n++;
        if (sl_n == W) begin
          sl_n = 0;
          if (exp_wire.size() == 0) chk(0, "R3 unexpected wire word", sl_sh, 0);
          else begin
            logic [W-1:0] e;
            e = exp_wire.pop_front();
            chk(sl_sh == e, "R3 wire word MSB first", sl_sh, e);
          end
        end
      end
      if (prev_sclk && !sclk) last_fall = cyc;
      if (!prev_ss && ss_n) begin t_rise = cyc; frames++; end
      if (rx_valid) begin
        if (exp_rx.size() == 0) chk(0, "R3 unexpected rx word", rx_data, 0);
        else begin
          logic [W-1:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R3 received word", rx_data, e);
        end
      end
      if (tx_valid && tx_ready) accepts++;
      prev_ss = ss_n; prev_sclk = sclk;
    end
  end

  task automatic pulse_set();
    frame_set = 1; @(negedge clk); frame_set = 0;
  endtask
  task automatic pulse_clr();
    frame_clr = 1; @(negedge clk); frame_clr = 0;
  endtask

  task automatic send(input logic [W-1:0] d, input logic e);
    exp_wire.push_back(d);
    exp_rx.push_back(~d);
    tx_data = d; tx_eof = e; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0; tx_eof = 0;
  endtask

  task automatic wait_frame_end();
    int f0;
    f0 = frames;
    while (frames == f0) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int acc0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ss_n == 1, "R1 select high", ss_n, 1);
    chk(sclk == 0, "R1 clock low", sclk, 0);
    chk(tx_ready == 0, "R1 ready low", tx_ready, 0);
    chk(frame_active == 0, "R1 frame bit clear", frame_active, 0);
    chk(xfer_done == 0 && rx_valid == 0, "R1 flags clear", xfer_done, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // single word closed by end-of-frame tag: L=2, T=3
    pulse_set();
    send(8'hA5, 1'b1);
    wait_frame_end();
    chk(first_rise - t_fall == 2*H*2 + H + 1, "R2 leading spacing", first_rise - t_fall, 2*H*2 + H + 1);
    chk(rises == W, "R3 edges per word", rises, W);
    chk(t_rise - last_fall == 2*H*3, "R6 trailing spacing", t_rise - last_fall, 2*H*3);
    chk(frame_active == 0, "R9 eof tag closes frame", frame_active, 0);
    chk(xfer_done == 1, "R10 done flag set", xfer_done, 1);
    repeat (10) @(negedge clk);
    chk(xfer_done == 1, "R10 done flag sticky", xfer_done, 1);
    done_clr = 1; @(negedge clk); done_clr = 0;
    chk(xfer_done == 0, "R10 done flag cleared", xfer_done, 0);

    // three words, frame cleared while the third shifts
    pulse_set();
    send(8'h11, 1'b0);
    send(8'h6C, 1'b0);
    send(8'hF0, 1'b0);
    pulse_clr();
    wait_frame_end();
    chk(rises == 3*W, "R4 R5 words kept in one select window", rises, 3*W);
    chk(t_rise - last_fall == 2*H*3, "R5 trail after finished word", t_rise - last_fall, 2*H*3);
    chk(frame_active == 0, "R5 frame bit cleared", frame_active, 0);

    // clear during leading spacing: L=4, T=3
    cfg_lead = 4'd3;
    acc0 = accepts;
    pulse_set();
    tx_data = 8'h3C; tx_valid = 1;
    while (ss_n) @(negedge clk);
    repeat (3) @(negedge clk);
    pulse_clr();
    wait_frame_end();
    tx_valid = 0;
    chk(rises == 0, "R8 no clock edges", rises, 0);
    chk(accepts == acc0, "R8 no word accepted", accepts - acc0, 0);
    chk(t_rise - t_fall == 2*H*(4 + 3), "R8 select window", t_rise - t_fall, 2*H*7);
    repeat (40) @(negedge clk);
    chk(ss_n == 1 && exp_rx.size() == 0, "R8 stays idle, nothing received", exp_rx.size(), 0);

    // next-frame spacing: L=1, G=3
    cfg_lead = 4'd0; cfg_gap = 4'd2;
    pulse_set();
    send(8'hC3, 1'b1);
    while (frame_active) @(negedge clk);
    pulse_set();
    send(8'h5A, 1'b1);
    wait_frame_end();
    chk(gap_len == 2*H*3 + 1, "R7 next-frame spacing", gap_len, 2*H*3 + 1);
    chk(first_rise - t_fall == 2*H*1 + H + 1, "R2 shortest lead", first_rise - t_fall, 2*H + H + 1);

    // longest spacings: L=16, T=16
    cfg_lead = 4'd15; cfg_trail = 4'd15; cfg_gap = 4'd0;
    repeat (20) @(negedge clk);
    pulse_set();
    send(8'h81, 1'b1);
    wait_frame_end();
    chk(first_rise - t_fall == 2*H*16 + H + 1, "R2 longest lead", first_rise - t_fall, 2*H*16 + H + 1);
    chk(t_rise - last_fall == 2*H*16, "R6 longest trail", t_rise - last_fall, 2*H*16);

    // strobe priority and ready gating
    repeat (10) @(negedge clk);
    frame_set = 1; frame_clr = 1; @(negedge clk); frame_set = 0; frame_clr = 0;
    chk(frame_active == 0, "R11 clear wins over set", frame_active, 0);
    pulse_set();
    chk(frame_active == 1, "R11 set strobe", frame_active, 1);
    repeat (5) @(negedge clk);
    chk(tx_ready == 0 && ss_n == 1, "R11 no ready while idle without word", tx_ready, 0);
    pulse_clr();
    chk(frame_active == 0, "R11 clear strobe", frame_active, 0);

    repeat (10) @(negedge clk);
    chk(exp_rx.size() == 0 && exp_wire.size() == 0, "R3 scoreboard drained",
        exp_rx.size() + exp_wire.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule